// File: doc/BRIEF.md
# Parallel Flash Byte-Program Sequencer

This block sits on the host side of an 8-bit asynchronous parallel flash device and turns a request for one byte into the device's full program sequence. A request carries a target address, a data byte, a flag marking the last byte of a batch and a mode bit. The sequencer issues the program opcode and then the address and data write. It then reads the device status register again and again until the device reports idle. Each read is a separate bus cycle with its own chip-enable and output-enable toggle.

When a check is due, it examines the error bits of the status and reports one outcome per request on a single-cycle response strobe. If any error bit is set it issues the clear-status opcode. Once a batch ends, or on any error or timeout, it writes the read-array opcode so the device can be read normally again. Setup, strobe and hold lengths of every bus cycle are set in clock cycles by parameters. A cycle-count limit bounds the busy polling.

The mode bit selects whether the full status check runs after every byte or only once, on the byte marked last. The device's error bits are sticky, so a single check at the end of a batch still sees a failure from an earlier byte.

Top module: `flash_prog_seq`

## Requirements
- R1: Each accepted request produces two bus write cycles in order: first the program opcode (parameter, default 8'h40) with the address lines at zero, then a write of the request's data byte to the request's address.
- R2: After the data write, the block reads the status register with one complete bus cycle per read, toggling both chip enable and output enable. It stops polling after the first read with bit 7 set, so the number of status reads is the number of busy (bit 7 clear) reads plus one.
- R3: The check classifies the final status. Bit 3 set gives code 3 (supply too low), and this takes priority over the other bits. Otherwise bit 4 or bit 5 set gives code 2 (write failed). Otherwise the code is 0 (success).
- R4: With check_each high every byte is checked. With check_each low only a request with req_last high is checked. An unchecked byte reports code 1 and issues neither clear-status nor read-array.
- R5: When a check finds bit 3, 4 or 5 set, the clear-status opcode (parameter, default 8'h50) is written before the response.
- R6: The read-array opcode 8'hFF is written before the response after a checked byte with req_last high, after any error code and after a timeout. It is never written for an error-free byte that is not last.
- R7: If bit 7 is still clear once POLL_LIMIT clock cycles of polling have passed, the response is code 4 (timeout) and read-array is written. Clear-status is not written.
- R8: fl_dq_oe is high only during write cycles. It is low whenever fl_oe_n is low, and it is low for at least one cycle before any output-enable strobe.
- R9: req_ready is high only while the block is idle. Every accepted request yields exactly one single-cycle rsp_valid pulse, and req_ready is low during it.
- R10: After reset fl_ce_n, fl_oe_n and fl_we_n are high, fl_dq_oe is low, req_ready is high and rsp_valid is low.
- R11: Every write-enable or output-enable strobe stays low for exactly PULSE_CYC cycles while chip enable is low. The two strobes are never low together, and fl_addr is stable while chip enable stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request accepted on valid and ready |
| req_addr | input | AW | Target byte address |
| req_data | input | 8 | Byte to program |
| req_last | input | 1 | Last byte of a batch |
| check_each | input | 1 | 1: check every byte, 0: check on last byte only |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_code | output | 3 | 0 ok, 1 unchecked, 2 write failed, 3 supply low, 4 timeout |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_addr | output | AW | Flash address lines |
| fl_dq_o | output | 8 | Data driven toward the flash |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_o |
| fl_dq_i | input | 8 | Data read from the flash |

## Verification
The bench drives a behavioural flash model whose busy length and injected faults are set per byte. A single checked byte with several busy reads separates correct read counting from early or late exit. A checked batch and an unchecked batch carrying a fault on a middle byte separate per-byte checking from deferred checking, and show that a sticky fault still surfaces at the end. A byte with both the supply-low and fail bits set tests the priority. A fault on a non-last byte tests the forced read-array. A device that never becomes ready tests the timeout path and shows that clear-status is not issued there.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

    typedef enum logic [2:0] {
        RSP_OK      = 3'd0,
        RSP_UNCHK   = 3'd1,
        RSP_WFAIL   = 3'd2,
        RSP_VPPLOW  = 3'd3,
        RSP_TIMEOUT = 3'd4
    } rsp_code_e;

    typedef enum logic [2:0] {
        BC_IDLE, BC_SETUP, BC_PULSE, BC_HOLD, BC_GAP
    } bus_phase_e;

    typedef enum logic [2:0] {
        S_IDLE, S_CMD, S_DATA, S_POLL, S_CLR, S_RA, S_RESP
    } seq_state_e;

    localparam int SR_READY_BIT = 7;
    localparam int SR_VPP_BIT   = 3;
    localparam int SR_FAIL_LO   = 4;
    localparam int SR_FAIL_HI   = 5;

    function automatic rsp_code_e classify(input logic [7:0] sr);
        if (sr[SR_VPP_BIT])                          return RSP_VPPLOW;
        else if (sr[SR_FAIL_LO] || sr[SR_FAIL_HI])   return RSP_WFAIL;
        else                                         return RSP_OK;
    endfunction

endpackage

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
    import flash_prog_pkg::*;
#(
    parameter int AW        = 18,
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 2,
    parameter int HOLD_CYC  = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          rd,
    input  logic [AW-1:0] addr_i,
    input  logic [7:0]    data_i,
    output logic          done,
    output logic [7:0]    rdata,
    output logic          ce_n,
    output logic          oe_n,
    output logic          we_n,
    output logic [AW-1:0] addr_o,
    output logic [7:0]    dq_o,
    output logic          dq_oe,
    input  logic [7:0]    dq_i
);
    localparam int CMAX = (SETUP_CYC > PULSE_CYC) ?
                          ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                          ((PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC);
    localparam int CW = $clog2(CMAX + 1);

    typedef struct packed {
        bus_phase_e     phase;
        logic [CW-1:0]  cnt;
        logic           rd;
        logic [AW-1:0]  addr;
        logic [7:0]     data;
        logic [7:0]     rdata;
    } bc_t;

    bc_t d, q;

    always_comb begin
        d = q;
        unique case (q.phase)
            BC_IDLE: if (start) begin
                d.phase = BC_SETUP;
                d.cnt   = '0;
                d.rd    = rd;
                d.addr  = addr_i;
                d.data  = data_i;
            end
            BC_SETUP: begin
                if (q.cnt == CW'(SETUP_CYC - 1)) begin
                    d.phase = BC_PULSE;
                    d.cnt   = '0;
                end else d.cnt = q.cnt + 1'b1;
            end
            BC_PULSE: begin
                if (q.cnt == CW'(PULSE_CYC - 1)) begin
                    d.phase = BC_HOLD;
                    d.cnt   = '0;
                    if (q.rd) d.rdata = dq_i;
                end else d.cnt = q.cnt + 1'b1;
            end
            BC_HOLD: begin
                if (q.cnt == CW'(HOLD_CYC - 1)) begin
                    d.phase = BC_GAP;
                    d.cnt   = '0;
                end else d.cnt = q.cnt + 1'b1;
            end
            default: d.phase = BC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.phase <= BC_IDLE;
            q.cnt   <= '0;
            q.rd    <= 1'b0;
            q.addr  <= '0;
            q.data  <= '0;
            q.rdata <= '0;
        end else begin
            q <= d;
        end
    end

    logic active;
    assign active = (q.phase == BC_SETUP) || (q.phase == BC_PULSE) || (q.phase == BC_HOLD);
    assign ce_n   = !active;
    assign oe_n   = !(q.rd && q.phase == BC_PULSE);
    assign we_n   = !(!q.rd && q.phase == BC_PULSE);
    assign dq_oe  = !q.rd && active;
    assign addr_o = q.addr;
    assign dq_o   = q.data;
    assign done   = (q.phase == BC_GAP);
    assign rdata  = q.rdata;
endmodule

// File: rtl/flash_poll_timer.sv
module flash_poll_timer #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                             cnt_d = '0;
        else if (en && cnt_q != TW'(LIMIT))  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == TW'(LIMIT));
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
    import flash_prog_pkg::*;
#(
    parameter int          AW         = 18,
    parameter int          SETUP_CYC  = 1,
    parameter int          PULSE_CYC  = 2,
    parameter int          HOLD_CYC   = 1,
    parameter int          POLL_LIMIT = 4096,
    parameter logic [7:0]  PROG_OP    = 8'h40,
    parameter logic [7:0]  CLR_OP     = 8'h50,
    parameter logic [7:0]  RA_OP      = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    input  logic          req_last,
    input  logic          check_each,
    output logic          rsp_valid,
    output logic [2:0]    rsp_code,
    output logic          fl_ce_n,
    output logic          fl_oe_n,
    output logic          fl_we_n,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_dq_o,
    output logic          fl_dq_oe,
    input  logic [7:0]    fl_dq_i
);
    typedef struct packed {
        seq_state_e     state;
        logic           launched;
        logic [AW-1:0]  addr;
        logic [7:0]     data;
        logic           last;
        logic           each;
        rsp_code_e      code;
    } seq_t;

    seq_t d, q;

    logic          bus_start, bus_rd, bus_done;
    logic [AW-1:0] bus_addr;
    logic [7:0]    bus_wdata, bus_rdata;
    logic          tmr_clr, tmr_en, tmr_expired;
    rsp_code_e     chk_code;

    assign chk_code = classify(bus_rdata);

    always_comb begin
        d         = q;
        bus_start = 1'b0;
        bus_rd    = (q.state == S_POLL);
        bus_addr  = (q.state == S_DATA) ? q.addr : '0;
        tmr_clr   = 1'b0;
        tmr_en    = (q.state == S_POLL);
        unique case (q.state)
            S_CMD:   bus_wdata = PROG_OP;
            S_DATA:  bus_wdata = q.data;
            S_CLR:   bus_wdata = CLR_OP;
            default: bus_wdata = RA_OP;
        endcase

        if (q.state != S_IDLE && q.state != S_RESP && !q.launched) begin
            bus_start  = 1'b1;
            d.launched = 1'b1;
        end

        unique case (q.state)
            S_IDLE: if (req_valid) begin
                d.state    = S_CMD;
                d.launched = 1'b0;
                d.addr     = req_addr;
                d.data     = req_data;
                d.last     = req_last;
                d.each     = check_each;
            end
            S_CMD: if (bus_done) begin
                d.state    = S_DATA;
                d.launched = 1'b0;
            end
            S_DATA: if (bus_done) begin
                d.state    = S_POLL;
                d.launched = 1'b0;
                tmr_clr    = 1'b1;
            end
            S_POLL: if (bus_done) begin
                d.launched = 1'b0;
                if (bus_rdata[SR_READY_BIT]) begin
                    if (q.each || q.last) begin
                        d.code = chk_code;
                        if (chk_code != RSP_OK) d.state = S_CLR;
                        else if (q.last)        d.state = S_RA;
                        else                    d.state = S_RESP;
                    end else begin
                        d.code  = RSP_UNCHK;
                        d.state = S_RESP;
                    end
                end else if (tmr_expired) begin
                    d.code  = RSP_TIMEOUT;
                    d.state = S_RA;
                end
            end
            S_CLR: if (bus_done) begin
                d.state    = S_RA;
                d.launched = 1'b0;
            end
            S_RA: if (bus_done) begin
                d.state    = S_RESP;
                d.launched = 1'b0;
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state    <= S_IDLE;
            q.launched <= 1'b0;
            q.addr     <= '0;
            q.data     <= '0;
            q.last     <= 1'b0;
            q.each     <= 1'b0;
            q.code     <= RSP_OK;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.state == S_IDLE);
    assign rsp_valid = (q.state == S_RESP);
    assign rsp_code  = q.code;

    flash_bus_cycle #(
        .AW(AW), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)
    ) u_bus (
        .clk(clk), .rst_n(rst_n), .start(bus_start), .rd(bus_rd),
        .addr_i(bus_addr), .data_i(bus_wdata), .done(bus_done), .rdata(bus_rdata),
        .ce_n(fl_ce_n), .oe_n(fl_oe_n), .we_n(fl_we_n), .addr_o(fl_addr),
        .dq_o(fl_dq_o), .dq_oe(fl_dq_oe), .dq_i(fl_dq_i)
    );

    flash_poll_timer #(.LIMIT(POLL_LIMIT)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .en(tmr_en), .expired(tmr_expired)
    );
endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk #(
    parameter int AW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [2:0]    rsp_code,
    input logic          fl_ce_n,
    input logic          fl_oe_n,
    input logic          fl_we_n,
    input logic [AW-1:0] fl_addr,
    input logic          fl_dq_oe
);
    p_dq_released_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> !fl_dq_oe);

    p_turnaround_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_dq_oe) |=> fl_oe_n);

    p_strobes_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_oe_n == 1'b0 && fl_we_n == 1'b0));

    p_strobe_in_select_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_oe_n || !fl_we_n) |-> !fl_ce_n);

    p_addr_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_ce_n && $past(!fl_ce_n)) |-> $stable(fl_addr));

    p_rsp_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_rsp_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    p_rsp_code_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_code <= 3'd4));
endmodule

bind flash_prog_seq flash_prog_seq_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
    .fl_addr(fl_addr), .fl_dq_oe(fl_dq_oe)
);

// File: tb/flash_prog_seq_tb.sv
module flash_prog_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 18;
    localparam int PULSE      = 2;
    localparam int LIMIT      = 300;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = '0;
    logic          req_last = 1'b0, check_each = 1'b0;
    logic          rsp_valid;
    logic [2:0]    rsp_code;
    logic          fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_dq_o, fl_dq_i;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_prog_seq #(.AW(AW), .PULSE_CYC(PULSE), .POLL_LIMIT(LIMIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_last(req_last),
        .check_each(check_each), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n), .fl_addr(fl_addr),
        .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i)
    );

    int checks = 0, errors = 0;
    bit done_flag = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- flash device model ----------------
    logic [7:0] mem [int];
    logic [7:0] sr_val = 8'h00, errbits = 8'h00, last_cmd = 8'h00;
    bit  expect_data = 0, ra_mode = 1, inj_fail = 0, inj_vpp = 0;
    int  busy_cfg = 0, busy_left = 0;
    int  n_prog = 0, n_clr = 0, n_ra = 0, n_reads = 0, n_cmd_addr_bad = 0;

    assign fl_dq_i = sr_val;

    always @(posedge fl_we_n) if (rst_n && !fl_ce_n) begin
        if (expect_data) begin
            if (inj_vpp)       errbits = errbits | 8'h18;
            else if (inj_fail) errbits = errbits | 8'h10;
            else               mem[int'(fl_addr)] = fl_dq_o;
            busy_left   = busy_cfg;
            expect_data = 0;
            n_prog++;
        end else begin
            if (fl_addr != '0) n_cmd_addr_bad++;
            case (fl_dq_o)
                8'h40, 8'h10: begin expect_data = 1; last_cmd = fl_dq_o; ra_mode = 0; end
                8'h50: begin errbits = 8'h00; n_clr++; end
                8'hFF: begin ra_mode = 1; n_ra++; end
                default: ;
            endcase
        end
    end

    always @(negedge fl_oe_n) if (rst_n && !fl_ce_n) begin
        n_reads++;
        if (busy_left > 0) begin
            sr_val = errbits;
            busy_left--;
        end else begin
            sr_val = 8'h80 | errbits;
        end
    end

    // ---------------- scoreboard ----------------
    logic [2:0] exp_q [$];
    int n_rsp = 0, n_acc = 0;

    always @(negedge clk) if (rst_n && rsp_valid) begin
        n_rsp++;
        if (exp_q.size() == 0) chk(0, "R9 unexpected response", int'(rsp_code), -1);
        else begin
            logic [2:0] e;
            e = exp_q.pop_front();
            chk(rsp_code == e, "R3/R4/R7 response code", int'(rsp_code), int'(e));
        end
    end

    // ---------------- bus monitor (R8, R11) ----------------
    int we_low = 0, oe_low = 0, width_bad = 0, dq_bad = 0;
    logic dq_oe_prev = 1'b0;
    always @(negedge clk) if (rst_n) begin
        if (!fl_oe_n && (fl_dq_oe || dq_oe_prev)) dq_bad++;
        dq_oe_prev = fl_dq_oe;
        if (!fl_we_n) we_low++;
        else if (we_low != 0) begin if (we_low != PULSE) width_bad++; we_low = 0; end
        if (!fl_oe_n) oe_low++;
        else if (oe_low != 0) begin if (oe_low != PULSE) width_bad++; oe_low = 0; end
    end

    // ---------------- driver ----------------
    task automatic send(input logic [AW-1:0] a, input logic [7:0] dat, input bit last,
                        input bit each, input logic [2:0] exp_code);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        exp_q.push_back(exp_code);
        req_addr = a; req_data = dat; req_last = last; check_each = each;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n_acc++;
        chk(req_ready == 1'b0, "R9 ready low while busy", int'(req_ready), 0);
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int ra0, clr0, rd0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(fl_ce_n && fl_oe_n && fl_we_n, "R10 strobes high", {fl_ce_n, fl_oe_n, fl_we_n}, 7);
        chk(!fl_dq_oe, "R10 bus released", int'(fl_dq_oe), 0);
        chk(req_ready && !rsp_valid, "R10 ready/rsp", {req_ready, rsp_valid}, 2);
        rst_n = 1'b1;

        // single checked byte, 3 busy reads
        busy_cfg = 3; ra0 = n_ra; clr0 = n_clr; rd0 = n_reads;
        send(18'h01234, 8'hA5, 1, 1, 3'd0);
        chk(last_cmd == 8'h40, "R1 program opcode", int'(last_cmd), 8'h40);
        chk(mem.exists(32'h1234) && mem[32'h1234] == 8'hA5, "R1 data at address",
            mem.exists(32'h1234) ? int'(mem[32'h1234]) : -1, 8'hA5);
        chk(n_reads - rd0 == 4, "R2 status read count", n_reads - rd0, 4);
        chk(n_ra - ra0 == 1 && ra_mode, "R6 read-array after last", n_ra - ra0, 1);
        chk(n_clr == clr0, "R5 no clear on success", n_clr - clr0, 0);

        // checked batch, all good, 1 busy read
        busy_cfg = 1; ra0 = n_ra; rd0 = n_reads;
        send(18'h00010, 8'h11, 0, 1, 3'd0);
        chk(n_ra == ra0, "R6 no read-array mid batch", n_ra - ra0, 0);
        send(18'h00011, 8'h22, 0, 1, 3'd0);
        send(18'h00012, 8'h33, 1, 1, 3'd0);
        chk(n_ra - ra0 == 1, "R6 one read-array per batch", n_ra - ra0, 1);
        chk(n_reads - rd0 == 6, "R2 reads across batch", n_reads - rd0, 6);
        chk(mem[32'h11] == 8'h22, "R1 batch data", int'(mem[32'h11]), 8'h22);

        // deferred check, fault on middle byte
        ra0 = n_ra; clr0 = n_clr;
        send(18'h00020, 8'h44, 0, 0, 3'd1);
        inj_fail = 1;
        send(18'h00021, 8'h55, 0, 0, 3'd1);
        inj_fail = 0;
        chk(n_clr == clr0 && n_ra == ra0, "R4 unchecked issues nothing",
            (n_clr - clr0) + (n_ra - ra0), 0);
        send(18'h00022, 8'h66, 1, 0, 3'd2);
        chk(n_clr - clr0 == 1, "R5 clear after deferred fail", n_clr - clr0, 1);
        chk(errbits == 8'h00, "R5 error bits cleared", int'(errbits), 0);
        chk(n_ra - ra0 == 1, "R6 read-array after batch", n_ra - ra0, 1);

        // supply low priority
        clr0 = n_clr; inj_vpp = 1;
        send(18'h00030, 8'h77, 1, 1, 3'd3);
        inj_vpp = 0;
        chk(n_clr - clr0 == 1, "R5 clear after supply low", n_clr - clr0, 1);

        // fault on non-last checked byte forces read-array
        ra0 = n_ra; clr0 = n_clr; inj_fail = 1;
        send(18'h00031, 8'h88, 0, 1, 3'd2);
        inj_fail = 0;
        chk(n_ra - ra0 == 1 && n_clr - clr0 == 1, "R6 read-array after error",
            n_ra - ra0, 1);

        // timeout
        ra0 = n_ra; clr0 = n_clr; busy_cfg = 100000;
        send(18'h00040, 8'h99, 1, 1, 3'd4);
        chk(n_ra - ra0 == 1, "R7 read-array after timeout", n_ra - ra0, 1);
        chk(n_clr == clr0, "R7 no clear on timeout", n_clr - clr0, 0);
        busy_left = 0; busy_cfg = 0;

        // recovery byte after timeout
        send(18'h00041, 8'h5A, 1, 1, 3'd0);
        chk(mem[32'h41] == 8'h5A, "R1 write after recovery", int'(mem[32'h41]), 8'h5A);

        repeat (5) @(negedge clk);
        chk(n_cmd_addr_bad == 0, "R1 command address zero", n_cmd_addr_bad, 0);
        chk(dq_bad == 0, "R8 bus released around reads", dq_bad, 0);
        chk(width_bad == 0, "R11 strobe width", width_bad, 0);
        chk(n_rsp == n_acc, "R9 one response per request", n_rsp, n_acc);
        finish_run();
    end
endmodule